// File: doc/BRIEF.md
# Flag-Setting ALU with Condition Gating

This block is the integer execution stage of a small load/store core. Each cycle it takes an operation code, two operands, a carry bit from the operand shifter, a set-flags request and a four-bit condition code. It produces the operation result and a write enable for the destination register. It keeps a four-bit status register holding negative, zero, carry and signed-overflow flags.

The condition code is tested against the status register as it stands before the current operation. A failed condition cancels the result write and the flag update, so every instruction, a branch included, can be predicated. Four compare-class operations are used only for their flags: they never write a result, and they update the flags whenever their condition passes.

The result, write enable and condition outcome are combinational functions of the inputs and the stored flags. The flags change on the rising clock edge. A synchronous reset clears them.

Top module: `flag_alu`

## Requirements
- R1: A synchronous reset clears the status register to 0000. `flags_o` bit 3 is N, bit 2 is Z, bit 1 is C and bit 0 is V.
- R2: The arithmetic opcodes are ADD=0 (A+B), ADC=1 (A+B+C), SUB=2 (A-B) and SBC=3 (A-B-NOT C), all taken modulo 2^W. For every opcode from 0 to 7, `res_o` shows the result whether or not the condition passes.
- R3: The logical opcodes are AND=4 (A&B), ORR=5 (A|B), EOR=6 (A^B) and BIC=7 (A&~B).
- R4: After an arithmetic update, N is the result MSB and Z is set when the result is zero. C is the adder carry-out, which for subtraction means no borrow. V is set on signed overflow. Adding all-ones and 1 gives 0 with NZCV=0110, and adding 1 to the largest positive value gives the most negative value with NZCV=1001.
- R5: After a logical update, N and Z come from the result, C is copied from `shc_i`, and V keeps its previous value.
- R6: CMP=8 (subtract), CMN=9 (add), TST=10 (AND) and TEQ=11 (XOR) never assert `res_we_o`. When their condition passes, they update all four flags by the subtract, add or logical rules, regardless of `set_flags_i`.
- R7: `cond_ok_o` evaluates `cond_i` against the stored flags. The codes are 0 Z, 1 !Z, 2 C, 3 !C, 4 N, 5 !N, 6 V, 7 !V, 8 C&!Z, 9 !C|Z, 10 N==V, 11 N!=V, 12 !Z&(N==V), 13 Z|(N!=V), and 14 and 15 are always true.
- R8: `res_we_o` is high only when the condition passes and the opcode is 0 to 7. A failed condition leaves the flags unchanged.
- R9: For opcodes 0 to 7, the flags update only when `set_flags_i` is high and the condition passes. Otherwise they hold.
- R10: Opcodes 12 to 15 are reserved. They write no result and leave the flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| op_i | input | 4 | Operation code |
| a_i | input | W | First operand |
| b_i | input | W | Second operand |
| shc_i | input | 1 | Carry out of the operand shifter |
| set_flags_i | input | 1 | Request to update flags (data operations) |
| cond_i | input | 4 | Condition code |
| res_o | output | W | Operation result |
| res_we_o | output | 1 | Destination write enable |
| cond_ok_o | output | 1 | Condition passed |
| flags_o | output | 4 | Stored flags {N,Z,C,V} |

## Verification
The bench builds two instances. The first uses W=8, so a dense grid of operand pairs can be swept across all sixteen opcodes. This grid reaches every carry, borrow and signed-overflow boundary of the 8-bit adder. The condition code, set-flags request and shifter carry rotate between vectors, and the flags are carried forward from one vector to the next. This chaining exercises every predicate against many flag states, along with ADC and SBC with both incoming carries. A second instance at W=32 covers the two wide-word flag examples.

// File: rtl/flag_alu_pkg.sv
package flag_alu_pkg;

  typedef enum logic [3:0] {
    OP_ADD = 4'd0, OP_ADC = 4'd1, OP_SUB = 4'd2, OP_SBC = 4'd3,
    OP_AND = 4'd4, OP_ORR = 4'd5, OP_EOR = 4'd6, OP_BIC = 4'd7,
    OP_CMP = 4'd8, OP_CMN = 4'd9, OP_TST = 4'd10, OP_TEQ = 4'd11
  } alu_op_e;

  localparam int unsigned FLAG_N = 3;
  localparam int unsigned FLAG_Z = 2;
  localparam int unsigned FLAG_C = 1;
  localparam int unsigned FLAG_V = 0;

  function automatic logic op_writes(input logic [3:0] op);
    return (op[3] == 1'b0);
  endfunction

  function automatic logic op_compare(input logic [3:0] op);
    return (op[3:2] == 2'b10);
  endfunction

  function automatic logic op_arith(input logic [3:0] op);
    return (op inside {OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_CMP, OP_CMN});
  endfunction

endpackage

// File: rtl/flag_alu_datapath.sv
module flag_alu_datapath
  import flag_alu_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [3:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [3:0]   flags_cur,
  input  logic         shc,
  output logic [W-1:0] res,
  output logic [3:0]   flags_new
);

  logic         invert_b;
  logic         cin;
  logic [W-1:0] bb;
  logic [W:0]   sum;
  logic [W-1:0] logic_res;
  logic         ovf;

  always_comb begin
    unique case (op)
      OP_SUB, OP_CMP: begin invert_b = 1'b1; cin = 1'b1; end
      OP_SBC:         begin invert_b = 1'b1; cin = flags_cur[FLAG_C]; end
      OP_ADC:         begin invert_b = 1'b0; cin = flags_cur[FLAG_C]; end
      default:        begin invert_b = 1'b0; cin = 1'b0; end
    endcase
  end

  assign bb  = invert_b ? ~b : b;
  assign sum = {1'b0, a} + {1'b0, bb} + {{W{1'b0}}, cin};
  assign ovf = (a[W-1] == bb[W-1]) && (sum[W-1] != a[W-1]);

  always_comb begin
    unique case (op)
      OP_AND, OP_TST: logic_res = a & b;
      OP_ORR:         logic_res = a | b;
      OP_EOR, OP_TEQ: logic_res = a ^ b;
      OP_BIC:         logic_res = a & ~b;
      default:        logic_res = '0;
    endcase
  end

  always_comb begin
    if (op_arith(op)) begin
      res       = sum[W-1:0];
      flags_new = {sum[W-1], (sum[W-1:0] == '0), sum[W], ovf};
    end else begin
      res       = logic_res;
      flags_new = {logic_res[W-1], (logic_res == '0), shc, flags_cur[FLAG_V]};
    end
  end

endmodule

// File: rtl/flag_alu_cond.sv
module flag_alu_cond
  import flag_alu_pkg::*;
#(
  parameter int unsigned NCODES = 16
) (
  input  logic [3:0] cond,
  input  logic [3:0] flags,
  output logic       pass
);

  localparam int unsigned NPAIRS = NCODES / 2;

  logic n, z, c, v;
  logic [NPAIRS-1:0] base;
  logic [NCODES-1:0] pred;

  assign n = flags[FLAG_N];
  assign z = flags[FLAG_Z];
  assign c = flags[FLAG_C];
  assign v = flags[FLAG_V];

  assign base[0] = z;
  assign base[1] = c;
  assign base[2] = n;
  assign base[3] = v;
  assign base[4] = c & ~z;
  assign base[5] = (n == v);
  assign base[6] = ~z & (n == v);
  assign base[7] = 1'b1;

  // Each even code tests a predicate, the following odd code its negation;
  // the last pair is the unconditional one.
  for (genvar i = 0; i < NPAIRS; i++) begin : g_pair
    if (i == NPAIRS - 1) begin : g_always
      assign pred[2*i]   = 1'b1;
      assign pred[2*i+1] = 1'b1;
    end else begin : g_test
      assign pred[2*i]   = base[i];
      assign pred[2*i+1] = ~base[i];
    end
  end

  assign pass = pred[cond];

endmodule

// File: rtl/flag_alu.sv
module flag_alu
  import flag_alu_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [3:0]   op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         shc_i,
  input  logic         set_flags_i,
  input  logic [3:0]   cond_i,
  output logic [W-1:0] res_o,
  output logic         res_we_o,
  output logic         cond_ok_o,
  output logic [3:0]   flags_o
);

  logic [3:0] flags_q;
  logic [3:0] flags_d;
  logic       pass;
  logic       upd;

  flag_alu_datapath #(.W(W)) u_dp (
    .op        (op_i),
    .a         (a_i),
    .b         (b_i),
    .flags_cur (flags_q),
    .shc       (shc_i),
    .res       (res_o),
    .flags_new (flags_d)
  );

  flag_alu_cond #(.NCODES(16)) u_cond (
    .cond  (cond_i),
    .flags (flags_q),
    .pass  (pass)
  );

  assign upd = pass && (op_compare(op_i) || (op_writes(op_i) && set_flags_i));

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= 4'b0000;
    end else if (upd) begin
      flags_q <= flags_d;
    end
  end

  assign res_we_o  = pass && op_writes(op_i);
  assign cond_ok_o = pass;
  assign flags_o   = flags_q;

endmodule

// File: rtl/flag_alu_chk.sv
module flag_alu_chk #(
  parameter int unsigned W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic [3:0]   op_i,
  input logic         set_flags_i,
  input logic [3:0]   cond_i,
  input logic [W-1:0] res_o,
  input logic         res_we_o,
  input logic         cond_ok_o,
  input logic [3:0]   flags_o
);

  logic rst_d;
  always_ff @(posedge clk) rst_d <= rst;

  always @(posedge clk) begin
    if (rst_d === 1'b1) begin
      AST_RESET_CLEAR: assert (flags_o == 4'b0000); // R1
    end
  end

  AST_NONDATA_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    op_i[3] |-> !res_we_o); // R6

  AST_WRITE_NEEDS_COND: assert property (@(posedge clk) disable iff (rst)
    res_we_o |-> cond_ok_o); // R8

  AST_FAIL_HOLDS_FLAGS: assert property (@(posedge clk) disable iff (rst)
    !cond_ok_o |=> $stable(flags_o)); // R8

  AST_NO_SET_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!op_i[3] && !set_flags_i) |=> $stable(flags_o)); // R9

  AST_RESERVED_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (op_i[3:2] == 2'b11) |=> $stable(flags_o)); // R10

  AST_EQ_TRACKS_Z: assert property (@(posedge clk) disable iff (rst)
    (cond_i == 4'd0) |-> (cond_ok_o == flags_o[2])); // R7

  AST_ZERO_FROM_RESULT: assert property (@(posedge clk) disable iff (rst)
    (res_we_o && set_flags_i) |=> (flags_o[2] == ($past(res_o) == '0))); // R4

  AST_LOGIC_KEEPS_V: assert property (@(posedge clk) disable iff (rst)
    (res_we_o && set_flags_i && op_i[2]) |=> (flags_o[0] == $past(flags_o[0]))); // R5

endmodule

bind flag_alu flag_alu_chk #(.W(W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .op_i        (op_i),
  .set_flags_i (set_flags_i),
  .cond_i      (cond_i),
  .res_o       (res_o),
  .res_we_o    (res_we_o),
  .cond_ok_o   (cond_ok_o),
  .flags_o     (flags_o)
);

// File: tb/flag_alu_tb.sv
module flag_alu_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [3:0]    op;
  logic [NW-1:0] a, b;
  logic          shc, sf;
  logic [3:0]    cond;
  logic [NW-1:0] res;
  logic          we, ok;
  logic [3:0]    flags;

  logic [31:0]   wa, wb, wres;
  logic          wwe, wok;
  logic [3:0]    wflags;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // expected stored flags
  int en, ez, ec, ev;

  flag_alu #(.W(NW)) u_dut (
    .clk(clk), .rst(rst), .op_i(op), .a_i(a), .b_i(b), .shc_i(shc),
    .set_flags_i(sf), .cond_i(cond), .res_o(res), .res_we_o(we),
    .cond_ok_o(ok), .flags_o(flags)
  );

  flag_alu #(.W(32)) u_dut_wide (
    .clk(clk), .rst(rst), .op_i(op), .a_i(wa), .b_i(wb), .shc_i(shc),
    .set_flags_i(sf), .cond_i(cond), .res_o(wres), .res_we_o(wwe),
    .cond_ok_o(wok), .flags_o(wflags)
  );

  task automatic chk(input bit good, input string tag, input longint act, input longint exp);
    checks++;
    if (!good) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int cond_model(input int cc);
    case (cc)
      0: return ez;
      1: return !ez;
      2: return ec;
      3: return !ec;
      4: return en;
      5: return !en;
      6: return ev;
      7: return !ev;
      8: return ec && !ez;
      9: return !ec || ez;
      10: return en == ev;
      11: return en != ev;
      12: return !ez && (en == ev);
      13: return ez || (en != ev);
      default: return 1;
    endcase
  endfunction

  function automatic int sgn(input int x);
    return (x >= 128) ? x - 256 : x;
  endfunction

  task automatic step(input int o, input int ai, input int bi, input int cc, input int s, input int sc);
    int r, cout, vv, is_ar, pass, upd, full, sr;
    string rtag;
    @(negedge clk);
    op = 4'(o); a = NW'(ai); b = NW'(bi); cond = 4'(cc); sf = s[0]; shc = sc[0];
    is_ar = 0; r = 0; cout = 0; vv = 0; full = 0; sr = 0;
    case (o)
      0, 9: begin is_ar = 1; full = ai + bi; sr = sgn(ai) + sgn(bi); end
      1:    begin is_ar = 1; full = ai + bi + ec; sr = sgn(ai) + sgn(bi) + ec; end
      2, 8: begin is_ar = 1; full = ai + (255 - bi) + 1; sr = sgn(ai) - sgn(bi); end
      3:    begin is_ar = 1; full = ai + (255 - bi) + ec; sr = sgn(ai) - sgn(bi) - (1 - ec); end
      4, 10: r = ai & bi;
      5:    r = ai | bi;
      6, 11: r = ai ^ bi;
      7:    r = ai & (~bi & 255);
      default: r = 0;
    endcase
    if (is_ar) begin
      r = full & 255; cout = (full >> 8) & 1; vv = (sr > 127 || sr < -128) ? 1 : 0;
    end
    pass = cond_model(cc);
    upd = pass && ((o >= 8 && o <= 11) || (o < 8 && s != 0));
    #1;
    chk(ok == pass[0], "R7 cond_ok", ok, pass);
    chk(we == (pass != 0 && o < 8), (o >= 12) ? "R10 res_we" : (o >= 8 ? "R6 res_we" : "R8 res_we"),
        we, (pass != 0 && o < 8));
    if (o < 8) begin
      rtag = is_ar ? "R2 result" : "R3 result";
      chk(res == NW'(r), rtag, res, r);
    end
    @(posedge clk);
    if (upd) begin
      en = (r >> 7) & 1; ez = (r == 0); ec = is_ar ? cout : sc; ev = is_ar ? vv : ev;
    end
    #1;
    rtag = !upd ? ((o >= 12) ? "R10 flags held" : (!pass ? "R8 flags held" : "R9 flags held"))
         : (o >= 8 ? "R6 flags" : (is_ar ? "R4 flags" : "R5 flags"));
    chk(flags == 4'({en[0], ez[0], ec[0], ev[0]}), rtag, flags, {en[0], ez[0], ec[0], ev[0]});
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int k;
    op = 0; a = 0; b = 0; shc = 0; sf = 0; cond = 4'd14; wa = 0; wb = 0;
    en = 0; ez = 0; ec = 0; ev = 0;
    // R1: flags after reset
    repeat (3) @(posedge clk);
    #1;
    chk(flags == 4'b0000, "R1 reset narrow", flags, 0);
    chk(wflags == 4'b0000, "R1 reset wide", wflags, 0);
    @(negedge clk); rst = 1'b0;

    // R4: wide examples on the 32-bit instance
    @(negedge clk);
    op = 4'd0; wa = 32'hFFFF_FFFF; wb = 32'd1; sf = 1'b1; cond = 4'd14;
    #1;
    chk(wres == 32'd0 && wwe, "R4 wide -1+1 result", wres, 0);
    @(posedge clk); #1;
    chk(wflags == 4'b0110, "R4 wide -1+1 flags", wflags, 4'b0110);
    @(negedge clk);
    wa = 32'h7FFF_FFFF; wb = 32'd1;
    #1;
    chk(wres == 32'h8000_0000, "R4 wide max+1 result", wres, 32'h8000_0000);
    @(posedge clk); #1;
    chk(wflags == 4'b1001, "R4 wide max+1 flags", wflags, 4'b1001);

    // narrow instance: resync model with its flags from the same two ops
    // (narrow saw a=0,b=0 ADD twice with set-flags: N0 Z1 C0 V0)
    en = 0; ez = 1; ec = 0; ev = 0;
    #1;
    chk(flags == 4'b0100, "R4 narrow zero add", flags, 4'b0100);

    // sweep: operand grid x all opcodes, rotating condition/set/shc
    k = 0;
    for (int ai = 0; ai < 256; ai += 5) begin
      for (int bi = 0; bi < 256; bi += 7) begin
        for (int o = 0; o < 16; o++) begin
          step(o, ai, bi, (k * 7 + ai) % 16, (k % 3 != 0) ? 1 : 0, (k / 2) % 2);
          k++;
        end
      end
    end
    // boundary operands
    step(0, 255, 1, 14, 1, 0);
    step(2, 0, 1, 15, 1, 0);
    step(1, 127, 0, 14, 1, 0);
    step(3, 128, 0, 14, 1, 0);
    step(8, 128, 1, 14, 0, 1);
    step(9, 127, 1, 14, 0, 1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule